// File: doc/BRIEF.md
# Low-Power Stop/Wait Sequencer

This block moves a small microcontroller core into and out of its two low-power modes. Instruction decode sends it a request for the deep mode (stop) or the light mode (wait). The block then drives the clock enables. Stop turns off the oscillator and freezes everything, including the watchdog. Wait freezes only the CPU clock, so the oscillator and the peripheral clocks keep running. A static option bit can turn the stop request into a plain no-operation.

On entry to stop, the block sends a one-cycle pulse that clears the core's interrupt mask bit, so that the external interrupt can wake the part. The interrupt-control mask bit is captured when stop is entered. If it was set at that moment, only reset can leave stop. A wake from stop turns the oscillator back on at once. The core stays held through a fixed count of bus cycles so the oscillator can settle, and a one-cycle resume strobe follows. A wake from wait needs no settling delay. The block never drives any reset or clear onto port logic, so I/O state is untouched across either mode.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to run mode from any state. Run mode drives `osc_en`=1, `cpu_clk_en`=1, `per_clk_en`=1, `wdog_halt`=0, `ccr_i_clr`=0 and `resume`=0.
- R2: In run mode with `stop_dis`=1, a `stop_req` has no effect. The outputs stay at the run values and no `ccr_i_clr` pulse is issued.
- R3: In run mode with `stop_dis`=0, a `stop_req` enters stop at the next edge. In stop, `osc_en`, `cpu_clk_en` and `per_clk_en` are 0 and `wdog_halt` is 1.
- R4: `ccr_i_clr` is high for exactly the first cycle in stop and low at all other times.
- R5: In stop, `stop_req`, `wait_req` and `irq_mask` changes have no effect. Only `irq_edge` or reset can leave stop.
- R6: If `irq_mask` was 1 at the edge that entered stop, `irq_edge` cannot leave stop, even after the mask drops. Only reset exits.
- R7: An `irq_edge` in stop (mask clear at entry) starts settling. `osc_en` is 1 from the next cycle, while `cpu_clk_en` and `per_clk_en` stay 0 and `wdog_halt` stays 1 for 4064 cycles. In the cycle after that, run outputs return and `resume` is high for one cycle.
- R8: A `wait_req` in run mode enters wait: `cpu_clk_en`=0, with `osc_en`=1, `per_clk_en`=1 and `wdog_halt`=0. An `irq_edge` with `irq_mask`=0 returns to run at the next edge and gives a one-cycle `resume`. An edge with `irq_mask`=1 is ignored.
- R9: `stop_req` and `wait_req` are ignored in every state other than run.
- R10: When `stop_req` and `wait_req` arrive together in run mode, stop wins if `stop_dis`=0. With `stop_dis`=1, wait is entered.
- R11: A reset during settling aborts the count. No `resume` follows unless a new wake occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Deep low-power request from instruction decode |
| wait_req | input | 1 | Light low-power request from instruction decode |
| stop_dis | input | 1 | Static option: stop request acts as a no-op |
| irq_edge | input | 1 | Detected active edge of the external interrupt |
| irq_mask | input | 1 | Interrupt-control mask bit for the external interrupt |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdog_halt | output | 1 | Freezes the watchdog timer |
| ccr_i_clr | output | 1 | One-cycle pulse clearing the core's interrupt mask bit |
| resume | output | 1 | One-cycle strobe telling the core to continue |

## Verification
The stop path is tried three ways: with the option bit set, with the mask clear at entry, and with the mask set at entry and cleared later. Together these separate the no-op case, a real wake, and a wake that must be refused. Wait is tried with masked and unmasked edges, which shows whether the live mask, rather than the latched one, is used there. Simultaneous requests under both option values expose the priority between stop and wait. A reset part-way through settling shows whether the count really aborts. Long seeded random runs of all inputs, rare resets included, are checked cycle by cycle against a reference state model kept in the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    parameter int STAB_CYCLES_DEF = 4064;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_STAB = 2'd2,
        ST_WAIT = 2'd3
    } lpm_state_e;

    typedef struct packed {
        logic stop_req;
        logic wait_req;
        logic stop_dis;
        logic irq_edge;
        logic irq_mask;
    } lpm_req_t;

    typedef struct packed {
        logic osc_en;
        logic cpu_en;
        logic per_en;
        logic wdog_halt;
    } lpm_gates_t;

    function automatic lpm_gates_t gates_for(lpm_state_e s);
        lpm_gates_t g;
        case (s)
            ST_RUN:  g = '{osc_en: 1'b1, cpu_en: 1'b1, per_en: 1'b1, wdog_halt: 1'b0};
            ST_STOP: g = '{osc_en: 1'b0, cpu_en: 1'b0, per_en: 1'b0, wdog_halt: 1'b1};
            ST_STAB: g = '{osc_en: 1'b1, cpu_en: 1'b0, per_en: 1'b0, wdog_halt: 1'b1};
            default: g = '{osc_en: 1'b1, cpu_en: 1'b0, per_en: 1'b1, wdog_halt: 1'b0};
        endcase
        return g;
    endfunction

    function automatic logic wake_allowed(lpm_req_t r, logic mask_bit);
        return r.irq_edge && !mask_bit;
    endfunction

endpackage

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
    parameter int STAB_CYCLES = lpm_pkg::STAB_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] TC = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q != TC) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = en && (cnt_q == TC);

    // R7: the count never runs past the terminal value
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TC);

    // R7: a fresh settling period always begins at zero
    p_cnt_start_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpm_req_t   req,
    input  logic       stab_done,
    output lpm_state_e state,
    output logic       ccr_clr,
    output logic       resume
);
    lpm_state_e state_q, state_d;
    logic       mask_lat_q, mask_lat_d;
    logic       clr_d, res_d;
    logic       clr_q, res_q;

    always_comb begin
        state_d    = state_q;
        mask_lat_d = mask_lat_q;
        clr_d      = 1'b0;
        res_d      = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (req.stop_req && !req.stop_dis) begin
                    state_d    = ST_STOP;
                    mask_lat_d = req.irq_mask;
                    clr_d      = 1'b1;
                end else if (req.wait_req) begin
                    state_d = ST_WAIT;
                end
            end
            ST_STOP: begin
                if (wake_allowed(req, mask_lat_q)) begin
                    state_d = ST_STAB;
                end
            end
            ST_STAB: begin
                if (stab_done) begin
                    state_d = ST_RUN;
                    res_d   = 1'b1;
                end
            end
            default: begin
                if (wake_allowed(req, req.irq_mask)) begin
                    state_d = ST_RUN;
                    res_d   = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            mask_lat_q <= 1'b0;
            clr_q      <= 1'b0;
            res_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            mask_lat_q <= mask_lat_d;
            clr_q      <= clr_d;
            res_q      <= res_d;
        end
    end

    assign state   = state_q;
    assign ccr_clr = clr_q;
    assign resume  = res_q;

    // R2: disabled stop request leaves the block in run with no mask clear
    p_dis_noop_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && req.stop_req && req.stop_dis && !req.wait_req)
        |=> (state_q == ST_RUN && !clr_q));

    // R4: the mask-clear pulse lasts one cycle
    p_clr_single_r4: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !clr_q);

    // R5: without an edge, stop is held
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && !req.irq_edge) |=> (state_q == ST_STOP));

    // R6: a mask latched at entry keeps stop closed to interrupts
    p_masked_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && mask_lat_q) |=> (state_q == ST_STOP));

    // R7: terminal count leads to run with a resume strobe
    p_resume_after_tc_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STAB && stab_done) |=> (state_q == ST_RUN && res_q));

    // R7: resume is a single-cycle strobe
    p_resume_single_r7: assert property (@(posedge clk) disable iff (rst)
        res_q |=> !res_q);

    // R8: unmasked edge ends wait at once
    p_wait_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && req.irq_edge && !req.irq_mask)
        |=> (state_q == ST_RUN && res_q));

    // R9: requests do not move the block out of wait
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !(req.irq_edge && !req.irq_mask))
        |=> (state_q == ST_WAIT));

endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    output lpm_gates_t gates
);
    always_comb begin
        gates = gates_for(state);
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int STAB_CYCLES = STAB_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic wait_req,
    input  logic stop_dis,
    input  logic irq_edge,
    input  logic irq_mask,
    output logic osc_en,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic wdog_halt,
    output logic ccr_i_clr,
    output logic resume
);
    lpm_req_t   req;
    lpm_state_e state;
    lpm_gates_t gates;
    logic       stab_done;

    assign req = '{stop_req: stop_req, wait_req: wait_req, stop_dis: stop_dis,
                   irq_edge: irq_edge, irq_mask: irq_mask};

    lpm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .stab_done (stab_done),
        .state     (state),
        .ccr_clr   (ccr_i_clr),
        .resume    (resume)
    );

    lpm_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (state == ST_STAB),
        .done (stab_done)
    );

    lpm_gate u_gate (
        .state (state),
        .gates (gates)
    );

    assign osc_en     = gates.osc_en;
    assign cpu_clk_en = gates.cpu_en;
    assign per_clk_en = gates.per_en;
    assign wdog_halt  = gates.wdog_halt;

    // R3: an enabled stop request shuts the oscillator and halts the watchdog
    p_stop_gates_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop_req && !stop_dis)
        |=> (!osc_en && !cpu_clk_en && !per_clk_en && wdog_halt && ccr_i_clr));

    // R4: the mask-clear pulse appears only while stopped
    p_clr_in_stop_r4: assert property (@(posedge clk) disable iff (rst)
        ccr_i_clr |-> (!osc_en && wdog_halt));

    // R7: core stays held whenever the oscillator is off or settling
    p_core_held_r7: assert property (@(posedge clk) disable iff (rst)
        wdog_halt |-> (!cpu_clk_en && !resume));

    // R8: wait keeps oscillator and peripherals alive
    p_wait_gates_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && wait_req && (stop_dis || !stop_req))
        |=> (osc_en && per_clk_en && !cpu_clk_en && !wdog_halt));

endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;

    localparam int STAB = 4064;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 1'b0, wait_req = 1'b0, stop_dis = 1'b0;
    logic irq_edge = 1'b0, irq_mask = 1'b0;
    logic osc_en, cpu_clk_en, per_clk_en, wdog_halt, ccr_i_clr, resume;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model: 0 run, 1 stop, 2 settle, 3 wait
    int m_st = 0;
    int m_cnt = 0;
    bit m_lat = 1'b0, m_clr = 1'b0, m_res = 1'b0;
    int res_seen;

    always #10 clk = ~clk;

    lpm_ctrl u_dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
        .stop_dis(stop_dis), .irq_edge(irq_edge), .irq_mask(irq_mask),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .wdog_halt(wdog_halt), .ccr_i_clr(ccr_i_clr), .resume(resume)
    );

    function automatic logic [3:0] exp_gates(int st);
        case (st)
            0:       return 4'b1110;
            1:       return 4'b0001;
            2:       return 4'b1001;
            default: return 4'b1010;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_st = 0; m_cnt = 0; m_lat = 0; m_clr = 0; m_res = 0;
        end else begin
            m_clr = 0; m_res = 0;
            case (m_st)
                0: if (stop_req && !stop_dis) begin
                       m_st = 1; m_clr = 1; m_lat = irq_mask;
                   end else if (wait_req) m_st = 3;
                1: if (irq_edge && !m_lat) begin m_st = 2; m_cnt = 0; end
                2: if (m_cnt == STAB - 1) begin m_st = 0; m_res = 1; end
                   else m_cnt++;
                default: if (irq_edge && !irq_mask) begin m_st = 0; m_res = 1; end
            endcase
        end
    endtask

    task automatic compare(input string tag);
        logic [3:0] act;
        act = {osc_en, cpu_clk_en, per_clk_en, wdog_halt};
        check(act === exp_gates(m_st), {tag, " gates"}, act, exp_gates(m_st));
        check(ccr_i_clr === m_clr, {tag, " ccr_i_clr"}, ccr_i_clr, m_clr);
        check(resume === m_res, {tag, " resume"}, resume, m_res);
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (resume === 1'b1) res_seen++;
        compare(tag);
    endtask

    task automatic idle_in();
        stop_req = 0; wait_req = 0; irq_edge = 0;
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", WD_CYCLES);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5731));
        rst = 1;
        repeat (2) cyc("R1 reset");
        rst = 0;

        // R2: disabled stop is a no-op
        stop_dis = 1; stop_req = 1;
        cyc("R2");
        check({osc_en, cpu_clk_en, per_clk_en, wdog_halt, ccr_i_clr} == 5'b11100,
              "R2 run kept", {osc_en, cpu_clk_en, per_clk_en, wdog_halt, ccr_i_clr}, 5'b11100);
        idle_in(); cyc("R2");

        // R3/R4: enter stop with the mask clear
        stop_dis = 0; irq_mask = 0; stop_req = 1;
        cyc("R3");
        check(ccr_i_clr === 1'b1, "R4 clear pulse", ccr_i_clr, 1);
        check(osc_en === 1'b0 && wdog_halt === 1'b1, "R3 stopped", {osc_en, wdog_halt}, 2'b01);
        idle_in(); cyc("R4");
        check(ccr_i_clr === 1'b0, "R4 pulse ended", ccr_i_clr, 0);

        // R5: other events ignored in stop
        stop_req = 1; wait_req = 1; irq_mask = 1;
        repeat (4) cyc("R5");
        check(osc_en === 1'b0, "R5 still stopped", osc_en, 0);
        stop_req = 0; wait_req = 0;
        irq_edge = 1;
        cyc("R7 wake");
        check(osc_en === 1'b1 && cpu_clk_en === 1'b0, "R7 osc back, core held",
              {osc_en, cpu_clk_en}, 2'b10);
        irq_edge = 0; irq_mask = 0;
        res_seen = 0;
        repeat (STAB - 1) cyc("R7 settle");
        check(cpu_clk_en === 1'b0 && res_seen == 0, "R7 held to last cycle", cpu_clk_en, 0);
        cyc("R7 resume");
        check(resume === 1'b1 && cpu_clk_en === 1'b1, "R7 resume strobe", {resume, cpu_clk_en}, 2'b11);
        cyc("R7");
        check(resume === 1'b0, "R7 strobe one cycle", resume, 0);

        // R6: mask set at entry blocks wake even after it drops
        irq_mask = 1; stop_req = 1;
        cyc("R6");
        idle_in(); irq_mask = 0; irq_edge = 1;
        repeat (3) cyc("R6");
        check(osc_en === 1'b0, "R6 edge refused", osc_en, 0);
        irq_edge = 0; rst = 1;
        cyc("R1 reset from stop");
        rst = 0;
        check(cpu_clk_en === 1'b1, "R1 run after reset", cpu_clk_en, 1);

        // R8/R9: wait
        wait_req = 1;
        cyc("R8");
        check(cpu_clk_en === 1'b0 && per_clk_en === 1'b1 && osc_en === 1'b1,
              "R8 wait gates", {osc_en, cpu_clk_en, per_clk_en}, 3'b101);
        wait_req = 1; stop_req = 1; irq_mask = 1; irq_edge = 1;
        repeat (3) cyc("R9");
        check(cpu_clk_en === 1'b0 && osc_en === 1'b1, "R9 requests ignored in wait",
              {osc_en, cpu_clk_en}, 2'b10);
        idle_in(); irq_mask = 0; irq_edge = 1;
        cyc("R8 exit");
        check(resume === 1'b1 && cpu_clk_en === 1'b1, "R8 immediate resume", {resume, cpu_clk_en}, 2'b11);
        irq_edge = 0; cyc("R8");

        // R10: priority
        stop_req = 1; wait_req = 1; stop_dis = 0;
        cyc("R10");
        check(osc_en === 1'b0, "R10 stop wins", osc_en, 0);
        idle_in(); irq_edge = 1; cyc("R10");
        irq_edge = 0;
        repeat (STAB) cyc("R7 settle");
        check(resume === 1'b1, "R10 back to run", resume, 1);
        stop_req = 1; wait_req = 1; stop_dis = 1;
        cyc("R10");
        check(osc_en === 1'b1 && cpu_clk_en === 1'b0 && per_clk_en === 1'b1,
              "R10 wait when disabled", {osc_en, cpu_clk_en, per_clk_en}, 3'b101);
        idle_in(); irq_edge = 1; cyc("R10"); irq_edge = 0; cyc("R10");

        // R11: reset aborts settling
        stop_dis = 0; stop_req = 1; cyc("R11");
        idle_in(); irq_edge = 1; cyc("R11");
        irq_edge = 0;
        repeat (100) cyc("R11 settle");
        rst = 1; cyc("R11 reset"); rst = 0;
        res_seen = 0;
        repeat (STAB + 20) cyc("R11 no resume");
        check(res_seen == 0, "R11 aborted count gives no resume", res_seen, 0);

        // seeded random mix against the model
        for (int i = 0; i < 20000; i++) begin
            stop_req = ($urandom % 8) == 0;
            wait_req = ($urandom % 8) == 0;
            stop_dis = ($urandom % 4) == 0;
            irq_edge = ($urandom % 16) == 0;
            irq_mask = ($urandom % 3) == 0;
            rst      = ($urandom % 997) == 0;
            cyc("R5 R9 random");
        end
        rst = 0; idle_in();

        done = 1;
        summary();
        $finish;
    end

endmodule